// File: doc/BRIEF.md
# Flash Command Register Controller

This block sits on the device side of a byte-wide flash memory and interprets bytes that the host writes on the data bus as commands. A write cycle has two edges. The address is captured when write-enable falls, and the data byte is captured when write-enable rises. The block then moves between array read, program setup, erase setup, active program, active erase, program-verify, erase-verify and a neutral wait state. It issues single-cycle start and stop strobes to an internal program/erase engine. It also steers the array address so that reads return either the byte at the host address or the byte under verification, with a margin flag raised during each verify.

Programming works on one byte at a time, in any address order. A program-verify command ends the active program operation. It then reads back only the address last programmed and ignores the bus address. After either setup command, two back-to-back FFH writes cancel the sequence without touching memory. The block then waits in a neutral state, with its read output disabled, until a new command arrives. All bus inputs are sampled on the block clock.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read state. No strobe or margin flag is asserted, and a read cycle returns the byte at the bus address. Reset asserted in any state returns the block to that condition.
- R2: In array-read, verify or neutral state, a write of 00H or of any code other than 40H, 20H and FFH selects array-read. In array-read state, a read cycle with chip-enable and output-enable low and write-enable high asserts data_oe_o and returns the array byte at addr_i.
- R3: After 40H, the next write programs one byte. The address is the one present when write-enable fell, and the data is the byte present when it rose. One cycle after the rising edge, prog_start_o pulses for exactly one cycle, with array_addr_o holding that address and prog_data_o holding that data.
- R4: Writing C0H while programming pulses prog_stop_o for one cycle after the write-enable rising edge. The block enters program-verify and holds margin_pgm_o high.
- R5: In program-verify, read cycles ignore addr_i and return the byte at the last programmed address.
- R6: Writing 20H then 20H pulses erase_start_o. A following A0H pulses erase_stop_o and enters erase-verify. In erase-verify, margin_ers_o is high and reads return the byte at the address latched on that write's falling edge.
- R7: After 40H or 20H, two consecutive FFH writes produce no start strobe. The block then enters neutral state, where data_oe_o stays low, until another command is written.
- R8: After a setup command, a single FFH followed by another byte does not abort. After 40H that byte is programmed, and after 20H a byte of 20H starts the erase.
- R9: Any write other than C0H during programming, or other than A0H during erasing, still pulses the matching stop strobe and is decoded as a new command.
- R10: data_oe_o is low whenever output-enable is high and in both setup states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, samples all bus inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Host address |
| data_i | input | 8 | Host write data |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| array_rdata_i | input | 8 | Byte read from the array at array_addr_o |
| array_addr_o | output | ADDR_W | Address presented to the array |
| data_o | output | 8 | Read data to the host |
| data_oe_o | output | 1 | Host data bus drive enable |
| prog_data_o | output | 8 | Byte to be programmed |
| prog_start_o | output | 1 | One-cycle program start strobe |
| prog_stop_o | output | 1 | One-cycle program end strobe |
| erase_start_o | output | 1 | One-cycle erase start strobe |
| erase_stop_o | output | 1 | One-cycle erase end strobe |
| margin_pgm_o | output | 1 | Program-verify margin condition |
| margin_ers_o | output | 1 | Erase-verify margin condition |

## Verification
The bench builds the block with ADDR_W = 8, so its 256-byte array model covers every address. Each byte is seeded with a pattern derived from its address, which makes a read from the wrong address visible. With this small address space, one directed write can change the address between the falling and rising write-enable edges, which shows which edge supplies the address. Verify reads use a host address that differs from the latched one, so ignoring addr_i produces a visibly different byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_PSETUP, ST_ESETUP, ST_PABORT, ST_EABORT,
    ST_PROG, ST_ERASE, ST_PVERIFY, ST_EVERIFY, ST_NEUTRAL
  } fc_state_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_PSET  = 8'h40;
  localparam logic [7:0] CMD_ESET  = 8'h20;
  localparam logic [7:0] CMD_PVFY  = 8'hC0;
  localparam logic [7:0] CMD_EVFY  = 8'hA0;
  localparam logic [7:0] CMD_RESET = 8'hFF;
endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              wr_done_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fall;

  assign fall      = we_q & ~we_ni & ~ce_ni;
  assign wr_done_o = ~we_q & we_ni & ~ce_ni;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      we_q <= we_ni;
      if (fall) addr_q <= addr_i;
    end
  end

  // R3: address stays frozen from falling edge through the rising edge
  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_q && !we_ni) |=> $stable(addr_q));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output fc_state_e         state_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [ADDR_W-1:0] ev_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              prog_start_o,
  output logic              prog_stop_o,
  output logic              erase_start_o,
  output logic              erase_stop_o
);
  fc_state_e state_q, state_d;
  logic do_prog, do_erase, end_prog, end_erase, cap_ev;

  function automatic fc_state_e decode(input logic [7:0] d);
    case (d)
      CMD_PSET: return ST_PSETUP;
      CMD_ESET: return ST_ESETUP;
      default:  return ST_READ;
    endcase
  endfunction

  always_comb begin
    state_d   = state_q;
    do_prog   = 1'b0;
    do_erase  = 1'b0;
    end_prog  = 1'b0;
    end_erase = 1'b0;
    cap_ev    = 1'b0;
    if (wr_done_i) begin
      case (state_q)
        ST_PSETUP: if (wr_data_i == CMD_RESET) state_d = ST_PABORT;
                   else begin state_d = ST_PROG; do_prog = 1'b1; end
        ST_PABORT: if (wr_data_i == CMD_RESET) state_d = ST_NEUTRAL;
                   else begin state_d = ST_PROG; do_prog = 1'b1; end
        ST_ESETUP, ST_EABORT: begin
          if (wr_data_i == CMD_ESET) begin state_d = ST_ERASE; do_erase = 1'b1; end
          else if (wr_data_i == CMD_RESET)
            state_d = (state_q == ST_ESETUP) ? ST_EABORT : ST_NEUTRAL;
          else state_d = decode(wr_data_i);
        end
        ST_PROG: begin
          end_prog = 1'b1;
          state_d  = (wr_data_i == CMD_PVFY) ? ST_PVERIFY : decode(wr_data_i);
        end
        ST_ERASE: begin
          end_erase = 1'b1;
          cap_ev    = (wr_data_i == CMD_EVFY);
          state_d   = cap_ev ? ST_EVERIFY : decode(wr_data_i);
        end
        default: state_d = decode(wr_data_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_READ;
      prog_addr_o   <= '0;
      ev_addr_o     <= '0;
      prog_data_o   <= '0;
      prog_start_o  <= 1'b0;
      prog_stop_o   <= 1'b0;
      erase_start_o <= 1'b0;
      erase_stop_o  <= 1'b0;
    end else begin
      state_q       <= state_d;
      prog_start_o  <= do_prog;
      prog_stop_o   <= end_prog;
      erase_start_o <= do_erase;
      erase_stop_o  <= end_erase;
      if (do_prog) begin
        prog_addr_o <= wr_addr_i;
        prog_data_o <= wr_data_i;
      end
      if (cap_ev) ev_addr_o <= wr_addr_i;
    end
  end

  assign state_o = state_q;

  p_stop_from_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stop_o |-> $past(state_q == ST_PROG));
  p_verify_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PVERIFY && $past(state_q == ST_PVERIFY)) |-> $stable(prog_addr_o));
  p_neutral_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEUTRAL) |-> (!prog_start_o && !erase_start_o));
  p_estart_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> (state_q == ST_ERASE));
endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  fc_state_e         state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [7:0]        array_rdata_i,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              margin_pgm_o,
  output logic              margin_ers_o
);
  logic rd_state;

  always_comb begin
    case (state_i)
      ST_PROG, ST_PVERIFY:  array_addr_o = prog_addr_i;
      ST_ERASE, ST_EVERIFY: array_addr_o = ev_addr_i;
      default:              array_addr_o = addr_i;
    endcase
  end

  assign rd_state     = (state_i == ST_READ) || (state_i == ST_PVERIFY) ||
                        (state_i == ST_EVERIFY);
  assign margin_pgm_o = (state_i == ST_PVERIFY);
  assign margin_ers_o = (state_i == ST_EVERIFY);
  assign data_oe_o    = rd_state & ~ce_ni & ~oe_ni & we_ni;
  assign data_o       = array_rdata_i;

  always_comb begin
    p_margin_excl_r6: assert ($onehot0({margin_pgm_o, margin_ers_o}));
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [7:0]        array_rdata_i,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic [7:0]        prog_data_o,
  output logic              prog_start_o,
  output logic              prog_stop_o,
  output logic              erase_start_o,
  output logic              erase_stop_o,
  output logic              margin_pgm_o,
  output logic              margin_ers_o
);
  logic              wr_done;
  logic [ADDR_W-1:0] wr_addr, prog_addr, ev_addr;
  logic [7:0]        wr_data;
  fc_state_e         state;

  flash_wr_strobe #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i, .data_i,
    .wr_done_o(wr_done), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni,
    .wr_done_i(wr_done), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .state_o(state), .prog_addr_o(prog_addr), .ev_addr_o(ev_addr),
    .prog_data_o, .prog_start_o, .prog_stop_o, .erase_start_o, .erase_stop_o
  );

  flash_rd_path #(.ADDR_W(ADDR_W)) u_rd (
    .state_i(state), .addr_i, .prog_addr_i(prog_addr), .ev_addr_i(ev_addr),
    .ce_ni, .we_ni, .oe_ni, .array_rdata_i,
    .array_addr_o, .data_o, .data_oe_o, .margin_pgm_o, .margin_ers_o
  );

  p_verify_port_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (margin_pgm_o && $past(margin_pgm_o)) |-> $stable(array_addr_o));
  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RDZ = 3'd2, OP_PS = 3'd3,
                         OP_ES = 3'd4, OP_PSTP = 3'd5, OP_ESTP = 3'd6, OP_MG = 3'd7;
  localparam int NV = 51;
  // {op, addr, data, expected, requirement number}
  localparam logic [30:0] TV [NV] = '{
    {OP_RD,  8'h03, 8'h00, 8'h59, 4'd2},  // R2
    {OP_WR,  8'h00, 8'h77, 8'h00, 4'd2},
    {OP_RD,  8'h04, 8'h00, 8'h5E, 4'd2},
    {OP_WR,  8'h00, 8'h40, 8'h00, 4'd3},  // R3
    {OP_WR,  8'h20, 8'hC3, 8'h00, 4'd3},
    {OP_PS,  8'h00, 8'h00, 8'd1,  4'd3},
    {OP_WR,  8'h00, 8'hC0, 8'h00, 4'd4},  // R4
    {OP_PSTP,8'h00, 8'h00, 8'd1,  4'd4},
    {OP_MG,  8'h00, 8'h00, 8'd2,  4'd4},
    {OP_RD,  8'h99, 8'h00, 8'hC3, 4'd5},  // R5
    {OP_WR,  8'h00, 8'h00, 8'h00, 4'd2},
    {OP_MG,  8'h00, 8'h00, 8'd0,  4'd2},
    {OP_RD,  8'h20, 8'h00, 8'hC3, 4'd3},
    {OP_WR,  8'h00, 8'h40, 8'h00, 4'd8},  // R8
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd8},
    {OP_WR,  8'h30, 8'h11, 8'h00, 4'd8},
    {OP_PS,  8'h00, 8'h00, 8'd2,  4'd8},
    {OP_WR,  8'h00, 8'hC0, 8'h00, 4'd5},
    {OP_RD,  8'h00, 8'h00, 8'h11, 4'd5},
    {OP_WR,  8'h00, 8'h40, 8'h00, 4'd7},  // R7
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd7},
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd7},
    {OP_RDZ, 8'h30, 8'h00, 8'h00, 4'd7},
    {OP_PS,  8'h00, 8'h00, 8'd2,  4'd7},
    {OP_PSTP,8'h00, 8'h00, 8'd2,  4'd7},
    {OP_WR,  8'h00, 8'h00, 8'h00, 4'd7},
    {OP_RD,  8'h30, 8'h00, 8'h11, 4'd7},
    {OP_WR,  8'h00, 8'h20, 8'h00, 4'd6},  // R6
    {OP_WR,  8'h00, 8'h20, 8'h00, 4'd6},
    {OP_ES,  8'h00, 8'h00, 8'd1,  4'd6},
    {OP_WR,  8'h05, 8'hA0, 8'h00, 4'd6},
    {OP_ESTP,8'h00, 8'h00, 8'd1,  4'd6},
    {OP_MG,  8'h00, 8'h00, 8'd1,  4'd6},
    {OP_RD,  8'h77, 8'h00, 8'h5F, 4'd6},
    {OP_WR,  8'h00, 8'h40, 8'h00, 4'd9},  // R9
    {OP_WR,  8'h50, 8'h22, 8'h00, 4'd9},
    {OP_WR,  8'h00, 8'h00, 8'h00, 4'd9},
    {OP_PSTP,8'h00, 8'h00, 8'd3,  4'd9},
    {OP_RD,  8'h50, 8'h00, 8'h22, 4'd9},
    {OP_WR,  8'h00, 8'h20, 8'h00, 4'd7},
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd7},
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd7},
    {OP_ES,  8'h00, 8'h00, 8'd1,  4'd7},
    {OP_RDZ, 8'h00, 8'h00, 8'h00, 4'd7},
    {OP_WR,  8'h00, 8'h20, 8'h00, 4'd8},
    {OP_WR,  8'h00, 8'hFF, 8'h00, 4'd8},
    {OP_WR,  8'h00, 8'h20, 8'h00, 4'd8},
    {OP_ES,  8'h00, 8'h00, 8'd2,  4'd8},
    {OP_WR,  8'h00, 8'h00, 8'h00, 4'd9},
    {OP_ESTP,8'h00, 8'h00, 8'd2,  4'd9},
    {OP_RD,  8'h50, 8'h00, 8'h22, 4'd9}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr = '0, array_addr;
  logic [7:0] data = '0, data_o, prog_data, rdata;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic data_oe, ps, pstp, es, estp, mg_p, mg_e;
  logic [7:0] mem [2**AW];
  int n_ps = 0, n_pstp = 0, n_es = 0, n_estp = 0;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .data_i(data), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .array_rdata_i(rdata), .array_addr_o(array_addr), .data_o,
    .data_oe_o(data_oe), .prog_data_o(prog_data), .prog_start_o(ps),
    .prog_stop_o(pstp), .erase_start_o(es), .erase_stop_o(estp),
    .margin_pgm_o(mg_p), .margin_ers_o(mg_e)
  );

  assign rdata = mem[array_addr];

  always_ff @(posedge clk) begin
    if (ps) mem[array_addr] <= prog_data;
    n_ps   <= n_ps + int'(ps);
    n_pstp <= n_pstp + int'(pstp);
    n_es   <= n_es + int'(es);
    n_estp <= n_estp + int'(estp);
  end

  task automatic chk(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a_fall, input logic [7:0] a_rise,
                        input logic [7:0] d);
    @(negedge clk); addr = a_fall; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = a_rise;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  // leaves bus in read cycle until the following negedge
  task automatic bus_rd(input logic [7:0] a, input logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = ~oe;
    @(posedge clk); #1;
  endtask

  task automatic bus_idle();
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(1, int'({ps, pstp, es, estp, mg_p, mg_e}), 0);
    bus_rd(8'h10, 1'b1);
    chk(1, int'(data_oe), 1);
    chk(1, int'(data_o), 8'h4A);
    bus_idle();

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] a, d, e;
      int r;
      {op, a, d, e} = TV[i][30:4];
      r = int'(TV[i][3:0]);
      case (op)
        OP_WR: bus_wr(a, a, d);
        OP_RD: begin
          bus_rd(a, 1'b1);
          chk(r, int'(data_oe), 1);
          chk(r, int'(data_o), int'(e));
          bus_idle();
        end
        OP_RDZ: begin
          bus_rd(a, 1'b1);
          chk(r, int'(data_oe), 0);
          bus_idle();
        end
        OP_PS:   chk(r, n_ps, int'(e));
        OP_ES:   chk(r, n_es, int'(e));
        OP_PSTP: chk(r, n_pstp, int'(e));
        OP_ESTP: chk(r, n_estp, int'(e));
        default: chk(r, int'({mg_p, mg_e}), int'(e));
      endcase
    end

    // R3: address taken at falling edge, not rising edge
    bus_wr(8'h00, 8'h00, 8'h40);
    // R10: no read drive in program setup
    bus_rd(8'h00, 1'b1);
    chk(10, int'(data_oe), 0);
    bus_idle();
    bus_wr(8'h60, 8'h61, 8'h33);
    chk(3, n_ps, 4);
    bus_wr(8'h00, 8'h00, 8'hC0);
    bus_wr(8'h00, 8'h00, 8'h00);
    bus_rd(8'h60, 1'b1);
    chk(3, int'(data_o), 8'h33);
    bus_idle();
    bus_rd(8'h61, 1'b1);
    chk(3, int'(data_o), 8'h3B);
    bus_idle();

    // R10: output-enable high blocks drive
    bus_rd(8'h61, 1'b0);
    chk(10, int'(data_oe), 0);
    bus_idle();

    // R1: reset mid-sequence returns to read
    bus_wr(8'h00, 8'h00, 8'h40);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    bus_wr(8'h70, 8'h70, 8'h99);
    chk(1, n_ps, 4);
    bus_rd(8'h70, 1'b1);
    chk(1, int'(data_oe), 1);
    chk(1, int'(data_o), 8'h2A);
    bus_idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule